// File: doc/BRIEF.md
# Pattern Rectangle Fill Engine

The engine paints an axis-aligned rectangle of an 8-bit-per-pixel frame buffer using a stored pattern tile. A tile is either a one-bit mask, where each set bit becomes a foreground colour and each clear bit a background colour, or a full-depth tile whose bytes are used directly. Each produced source pixel is merged with the pixel already on screen by a raster operation: plain copy or exclusive-or.

A command is presented on the `cmd_*` inputs together with a one-cycle `start`. It names a tile slot, the tile dimensions, the destination rectangle, the colours, the raster operation and an addressing mode. In tile-following-screen mode the tile repeats across the screen on a grid anchored at screen origin. In anchored mode a caller-chosen tile coordinate lands on the rectangle's top-left pixel. The engine reads tile words and frame-buffer words through two synchronous read ports with one cycle of latency. It rewrites one byte per pixel through a byte-enabled write port and pulses `done` when the rectangle is finished.

Top module: `pattern_fill_engine`

## Requirements
- R1: In tile-following-screen mode (`cmd_explicit`=0) the tile pixel used at screen position (x, y) is (x mod tile width, y mod tile height), for tile dimensions 1 to 32.
- R2: In anchored mode (`cmd_explicit`=1) the tile pixel used at rectangle offset (i, j) is ((sx + i) mod tile width, (sy + j) mod tile height), also when sx or sy exceed the tile size.
- R3: A one-bit tile (`cmd_bitmap`=1) row py of slot id sits in tile word id*256 + py*8, tile column px is bit px of that word (bit 0 leftmost); a set bit yields `cmd_fg`, a clear bit yields `cmd_bg`.
- R4: A full-depth tile (`cmd_bitmap`=0) pixel (px, py) of slot id is bits 8k+7:8k of tile word id*256 + py*8 + px/4, with k = px mod 4.
- R5: `cmd_rop`=0 writes the source pixel unchanged; `cmd_rop`=1 writes source XOR the existing destination pixel.
- R6: Screen pixel (x, y) lives in byte lane x mod 4 (bits 8k+7:8k) of frame-buffer word y*(screen width/4) + x/4; every write enables exactly that one lane, so neighbouring pixels in the word keep their values.
- R7: Pixels are written once each, in row-major order (left to right, then top to bottom), and each write is to the word read on the cycle before.
- R8: `busy` is high from the cycle after an accepted `start` until `done`; `done` is a single-cycle pulse in the cycle after the last write.
- R9: A command with zero rectangle width, zero rectangle height or a zero tile dimension performs no write and raises `done` in the cycle after `start` is accepted.
- R10: `start` is ignored while `busy` is high; the running command completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the command on the cmd inputs when idle |
| cmd_pat_id | input | 2 | Tile slot |
| cmd_bitmap | input | 1 | 1: one-bit tile, 0: full-depth tile |
| cmd_explicit | input | 1 | 1: anchored mode, 0: tile follows screen |
| cmd_rop | input | 1 | 0: copy, 1: XOR with destination |
| cmd_dx | input | 6 | Rectangle left column |
| cmd_dy | input | 5 | Rectangle top row |
| cmd_w | input | 7 | Rectangle width in pixels |
| cmd_h | input | 6 | Rectangle height in pixels |
| cmd_sx | input | 5 | Anchor column in the tile |
| cmd_sy | input | 5 | Anchor row in the tile |
| cmd_pw | input | 6 | Tile width (1 to 32) |
| cmd_ph | input | 6 | Tile height (1 to 32) |
| cmd_fg | input | 8 | Colour for set mask bits |
| cmd_bg | input | 8 | Colour for clear mask bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pat_re | output | 1 | Tile read strobe |
| pat_addr | output | 10 | Tile word address |
| pat_rdata | input | 32 | Tile word, one cycle after pat_re |
| fb_re | output | 1 | Frame-buffer read strobe |
| fb_raddr | output | 9 | Frame-buffer read address |
| fb_rdata | input | 32 | Frame-buffer word, one cycle after fb_re |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_waddr | output | 9 | Frame-buffer write address |
| fb_wdata | output | 32 | Write data (pixel in every lane) |
| fb_be | output | 4 | Byte enables |

## Verification
Small tiles whose sizes do not divide the rectangle offsets separate a correct modulo walk from one that resets per row or per word, while anchors larger than the tile exercise the initial reduction. One-bit and full-depth tiles are each run in both addressing modes, and XOR fills over a non-uniform screen tell a merge from a plain store. A full-width row, a corner pixel and a sweep of thirty-two mixed commands check lane selection and word addressing at the edges, zero-size commands check early completion, and a second `start` issued mid-run must leave the picture unchanged.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PREP = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_FIN  = 3'd4
    } fill_state_e;

    localparam int PIX_BITS  = 8;
    localparam int WORD_BITS = 32;
    localparam logic ROP_COPY = 1'b0;
    localparam logic ROP_XOR  = 1'b1;
endpackage

// File: rtl/pfe_addr_gen.sv
module pfe_addr_gen #(
    parameter int XW   = 6,
    parameter int YW   = 5,
    parameter int PCW  = 5,
    parameter int IDW  = 2,
    parameter int FBAW = XW - 2 + YW,
    parameter int PAW  = IDW + 2 * PCW - 2
) (
    input  logic [XW-1:0]   dx,
    input  logic [YW-1:0]   dy,
    input  logic [XW-1:0]   cx,
    input  logic [YW-1:0]   cy,
    input  logic [IDW-1:0]  id,
    input  logic            is_bmp,
    input  logic [PCW-1:0]  px,
    input  logic [PCW-1:0]  py,
    output logic [FBAW-1:0] fb_addr,
    output logic [1:0]      fb_lane,
    output logic [PAW-1:0]  pat_addr,
    output logic [1:0]      pat_lane
);
    logic [XW-1:0] scr_x;
    logic [YW-1:0] scr_y;

    always_comb begin
        scr_x    = dx + cx;
        scr_y    = dy + cy;
        // word-per-row layout: row index above the word-within-row index
        fb_addr  = {scr_y, scr_x[XW-1:2]};
        fb_lane  = scr_x[1:0];
        // mask rows use the first word of each row slot
        pat_addr = {id, py, (is_bmp ? {(PCW-2){1'b0}} : px[PCW-1:2])};
        pat_lane = px[1:0];
    end
endmodule

// File: rtl/pfe_pixel_alu.sv
module pfe_pixel_alu
    import pfe_pkg::*;
#(
    parameter int PCW = 5
) (
    input  logic                 is_bmp,
    input  logic                 rop,
    input  logic [PIX_BITS-1:0]  fg,
    input  logic [PIX_BITS-1:0]  bg,
    input  logic [WORD_BITS-1:0] pat_word,
    input  logic [PCW-1:0]       pat_bit,
    input  logic [1:0]           pat_lane,
    input  logic [WORD_BITS-1:0] fb_word,
    input  logic [1:0]           fb_lane,
    output logic [WORD_BITS-1:0] wdata,
    output logic [3:0]           be
);
    logic [PIX_BITS-1:0] src_pix;
    logic [PIX_BITS-1:0] dst_pix;
    logic [PIX_BITS-1:0] out_pix;

    always_comb begin
        if (is_bmp) src_pix = pat_word[pat_bit] ? fg : bg;
        else        src_pix = pat_word[{pat_lane, 3'b000} +: PIX_BITS];
        dst_pix = fb_word[{fb_lane, 3'b000} +: PIX_BITS];
        out_pix = (rop == ROP_XOR) ? (src_pix ^ dst_pix) : src_pix;
        wdata   = {4{out_pix}};
        be      = 4'b0001 << fb_lane;
    end
endmodule

// File: rtl/pattern_fill_engine.sv
module pattern_fill_engine
    import pfe_pkg::*;
#(
    parameter int SCR_W   = 64,
    parameter int SCR_H   = 32,
    parameter int PAT_DIM = 32,
    parameter int PAT_NUM = 4,
    localparam int XW   = $clog2(SCR_W),
    localparam int YW   = $clog2(SCR_H),
    localparam int PCW  = $clog2(PAT_DIM),
    localparam int PDW  = PCW + 1,
    localparam int IDW  = $clog2(PAT_NUM),
    localparam int FBAW = XW - 2 + YW,
    localparam int PAW  = IDW + 2 * PCW - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IDW-1:0]  cmd_pat_id,
    input  logic            cmd_bitmap,
    input  logic            cmd_explicit,
    input  logic            cmd_rop,
    input  logic [XW-1:0]   cmd_dx,
    input  logic [YW-1:0]   cmd_dy,
    input  logic [XW:0]     cmd_w,
    input  logic [YW:0]     cmd_h,
    input  logic [PCW-1:0]  cmd_sx,
    input  logic [PCW-1:0]  cmd_sy,
    input  logic [PDW-1:0]  cmd_pw,
    input  logic [PDW-1:0]  cmd_ph,
    input  logic [7:0]      cmd_fg,
    input  logic [7:0]      cmd_bg,
    output logic            busy,
    output logic            done,
    output logic            pat_re,
    output logic [PAW-1:0]  pat_addr,
    input  logic [31:0]     pat_rdata,
    output logic            fb_re,
    output logic [FBAW-1:0] fb_raddr,
    input  logic [31:0]     fb_rdata,
    output logic            fb_we,
    output logic [FBAW-1:0] fb_waddr,
    output logic [31:0]     fb_wdata,
    output logic [3:0]      fb_be
);
    localparam int PXW = (XW > PDW) ? XW : PDW;
    localparam int PYW = (YW > PDW) ? YW : PDW;

    typedef struct packed {
        fill_state_e     st;
        logic [IDW-1:0]  id;
        logic            bmp;
        logic            rop;
        logic [XW-1:0]   dx;
        logic [YW-1:0]   dy;
        logic [XW:0]     w;
        logic [YW:0]     h;
        logic [PDW-1:0]  pw;
        logic [PDW-1:0]  ph;
        logic [7:0]      fg;
        logic [7:0]      bg;
        logic [XW-1:0]   cx;
        logic [YW-1:0]   cy;
        logic [PXW-1:0]  px;
        logic [PXW-1:0]  px0;
        logic [PYW-1:0]  py;
    } fill_regs_t;

    fill_regs_t r_d, r_q;

    logic [PXW-1:0]  px_inc, px_next;
    logic [PYW-1:0]  py_inc, py_next;
    logic            row_end, last_row, zero_cmd;
    logic [FBAW-1:0] word_addr;
    logic [1:0]      fb_lane, pat_lane;

    always_comb begin
        px_inc   = r_q.px + PXW'(1);
        px_next  = (px_inc == PXW'(r_q.pw)) ? '0 : px_inc;
        py_inc   = r_q.py + PYW'(1);
        py_next  = (py_inc == PYW'(r_q.ph)) ? '0 : py_inc;
        row_end  = ((XW+1)'(r_q.cx) + (XW+1)'(1)) == r_q.w;
        last_row = ((YW+1)'(r_q.cy) + (YW+1)'(1)) == r_q.h;
        zero_cmd = (cmd_w == '0) || (cmd_h == '0) || (cmd_pw == '0) || (cmd_ph == '0);

        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.id  = cmd_pat_id;
                    r_d.bmp = cmd_bitmap;
                    r_d.rop = cmd_rop;
                    r_d.dx  = cmd_dx;
                    r_d.dy  = cmd_dy;
                    r_d.w   = cmd_w;
                    r_d.h   = cmd_h;
                    r_d.pw  = cmd_pw;
                    r_d.ph  = cmd_ph;
                    r_d.fg  = cmd_fg;
                    r_d.bg  = cmd_bg;
                    r_d.cx  = '0;
                    r_d.cy  = '0;
                    r_d.px  = cmd_explicit ? PXW'(cmd_sx) : PXW'(cmd_dx);
                    r_d.py  = cmd_explicit ? PYW'(cmd_sy) : PYW'(cmd_dy);
                    r_d.st  = zero_cmd ? ST_FIN : ST_PREP;
                end
            end
            ST_PREP: begin
                // reduce the starting tile coordinate by repeated subtraction
                if (r_q.px >= PXW'(r_q.pw)) begin
                    r_d.px = r_q.px - PXW'(r_q.pw);
                end else if (r_q.py >= PYW'(r_q.ph)) begin
                    r_d.py = r_q.py - PYW'(r_q.ph);
                end else begin
                    r_d.px0 = r_q.px;
                    r_d.st  = ST_RD;
                end
            end
            ST_RD: r_d.st = ST_WR;
            ST_WR: begin
                r_d.st = ST_RD;
                if (row_end) begin
                    r_d.cx = '0;
                    r_d.px = r_q.px0;
                    r_d.py = py_next;
                    if (last_row) r_d.st = ST_FIN;
                    else          r_d.cy = r_q.cy + YW'(1);
                end else begin
                    r_d.cx = r_q.cx + XW'(1);
                    r_d.px = px_next;
                end
            end
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    pfe_addr_gen #(
        .XW(XW), .YW(YW), .PCW(PCW), .IDW(IDW), .FBAW(FBAW), .PAW(PAW)
    ) u_addr (
        .dx(r_q.dx), .dy(r_q.dy), .cx(r_q.cx), .cy(r_q.cy),
        .id(r_q.id), .is_bmp(r_q.bmp),
        .px(r_q.px[PCW-1:0]), .py(r_q.py[PCW-1:0]),
        .fb_addr(word_addr), .fb_lane(fb_lane),
        .pat_addr(pat_addr), .pat_lane(pat_lane)
    );

    pfe_pixel_alu #(.PCW(PCW)) u_alu (
        .is_bmp(r_q.bmp), .rop(r_q.rop), .fg(r_q.fg), .bg(r_q.bg),
        .pat_word(pat_rdata), .pat_bit(r_q.px[PCW-1:0]), .pat_lane(pat_lane),
        .fb_word(fb_rdata), .fb_lane(fb_lane),
        .wdata(fb_wdata), .be(fb_be)
    );

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = (r_q.st == ST_FIN);
    assign pat_re   = (r_q.st == ST_RD);
    assign fb_re    = (r_q.st == ST_RD);
    assign fb_we    = (r_q.st == ST_WR);
    assign fb_raddr = word_addr;
    assign fb_waddr = word_addr;

    // tile coordinate is always inside the tile when it is fetched
    assert_tile_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pat_re |-> (r_q.px < PXW'(r_q.pw)) && (r_q.py < PYW'(r_q.ph)));

    assert_single_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> ($countones(fb_be) == 1));

    assert_rmw_same_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> ($past(fb_re) && ($past(fb_raddr) == fb_waddr)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(busy)) |-> ($past(fb_we) || $past(r_q.st == ST_IDLE)));

    assert_zero_quick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((cmd_w == '0) || (cmd_h == '0) || (cmd_pw == '0) || (cmd_ph == '0)))
        |=> (done && !fb_we));

    assert_stay_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/pattern_fill_engine_tb_top.sv
module pattern_fill_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd_pat_id = '0;
    logic        cmd_bitmap = 1'b0, cmd_explicit = 1'b0, cmd_rop = 1'b0;
    logic [5:0]  cmd_dx = '0;
    logic [4:0]  cmd_dy = '0;
    logic [6:0]  cmd_w = '0;
    logic [5:0]  cmd_h = '0;
    logic [4:0]  cmd_sx = '0, cmd_sy = '0;
    logic [5:0]  cmd_pw = '0, cmd_ph = '0;
    logic [7:0]  cmd_fg = '0, cmd_bg = '0;
    logic        busy, done, pat_re, fb_re, fb_we;
    logic [9:0]  pat_addr;
    logic [8:0]  fb_raddr, fb_waddr;
    logic [31:0] pat_rdata, fb_rdata, fb_wdata;
    logic [3:0]  fb_be;

    logic [31:0] fbm  [0:511];
    logic [31:0] expm [0:511];
    logic [31:0] patm [0:1023];

    int ncyc = 0, last_we = 0, wr_cnt = 0, ord_bad = 0;
    int m_dx = 0, m_dy = 0, m_w = 0;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    pattern_fill_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_pat_id(cmd_pat_id), .cmd_bitmap(cmd_bitmap), .cmd_explicit(cmd_explicit),
        .cmd_rop(cmd_rop), .cmd_dx(cmd_dx), .cmd_dy(cmd_dy), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .cmd_sx(cmd_sx), .cmd_sy(cmd_sy), .cmd_pw(cmd_pw), .cmd_ph(cmd_ph),
        .cmd_fg(cmd_fg), .cmd_bg(cmd_bg), .busy(busy), .done(done),
        .pat_re(pat_re), .pat_addr(pat_addr), .pat_rdata(pat_rdata),
        .fb_re(fb_re), .fb_raddr(fb_raddr), .fb_rdata(fb_rdata),
        .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wdata(fb_wdata), .fb_be(fb_be)
    );

    function automatic logic [31:0] fb_init(int a);
        return (a * 32'h0100_0193) ^ 32'hA5A5_3C3C;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // memories with one cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) fbm[i] <= fb_init(i);
        end else begin
            if (fb_re) fb_rdata <= fbm[fb_raddr];
            if (fb_we) fbm[fb_waddr] <= merge(fbm[fb_waddr], fb_wdata, fb_be);
        end
        if (pat_re) pat_rdata <= patm[pat_addr];
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        ncyc <= ncyc + 1;
        if (ncyc > 150000) begin
            errors++;
            $display("FAIL R8 watchdog: actual %0d cycles expected below 150000", ncyc);
            summary();
            $finish;
        end
    end

    // write monitor: row-major order and lane (R6, R7)
    always @(negedge clk) begin
        if (rst_n && fb_we) begin
            int ex, ey;
            ex = (m_w > 0) ? m_dx + wr_cnt % m_w : 0;
            ey = (m_w > 0) ? m_dy + wr_cnt / m_w : 0;
            if (fb_waddr !== 9'(ey * 16 + ex / 4) || fb_be !== (4'b0001 << (ex % 4)))
                ord_bad++;
            wr_cnt++;
            last_we = ncyc;
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exv);
        end
    endtask

    function automatic logic [7:0] tile_pix(int id, int bmp, int px, int py, logic [7:0] fg, logic [7:0] bg);
        int base = id * 256 + py * 8;
        if (bmp != 0) return patm[base][px] ? fg : bg;
        return patm[base + px / 4][8 * (px % 4) +: 8];
    endfunction

    task automatic run_cmd(input int id, input int bmp, input int expl, input int rop,
                           input int dx, input int dy, input int w, input int h,
                           input int sx, input int sy, input int pw, input int ph,
                           input int fg, input int bg, input int poke, input string tag);
        bit nz, b_after, dn2;
        int waited, gap, bad, first;
        nz = (w > 0) && (h > 0) && (pw > 0) && (ph > 0);
        if (nz) begin
            for (int j = 0; j < h; j++) begin
                for (int i = 0; i < w; i++) begin
                    int x, y, px, py, a, l;
                    logic [7:0] s, d;
                    x = dx + i; y = dy + j;
                    px = (expl != 0) ? (sx + i) % pw : x % pw;
                    py = (expl != 0) ? (sy + j) % ph : y % ph;
                    s = tile_pix(id, bmp, px, py, 8'(fg), 8'(bg));
                    a = y * 16 + x / 4; l = x % 4;
                    d = expm[a][8 * l +: 8];
                    expm[a][8 * l +: 8] = (rop != 0) ? (s ^ d) : s;
                end
            end
        end
        @(negedge clk);
        cmd_pat_id = 2'(id); cmd_bitmap = 1'(bmp); cmd_explicit = 1'(expl); cmd_rop = 1'(rop);
        cmd_dx = 6'(dx); cmd_dy = 5'(dy); cmd_w = 7'(w); cmd_h = 6'(h);
        cmd_sx = 5'(sx); cmd_sy = 5'(sy); cmd_pw = 6'(pw); cmd_ph = 6'(ph);
        cmd_fg = 8'(fg); cmd_bg = 8'(bg);
        m_dx = dx; m_dy = dy; m_w = w; wr_cnt = 0; ord_bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        b_after = busy;
        waited = 0;
        if (poke != 0) begin
            repeat (3) @(negedge clk);
            cmd_dx = 6'(dx + 5); cmd_w = 7'd1; cmd_rop = ~cmd_rop; cmd_fg = ~cmd_fg;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            waited = 4;
        end
        while (!done) begin
            @(negedge clk);
            waited++;
        end
        gap = ncyc - last_we;
        @(negedge clk);
        dn2 = done;
        if (nz) begin
            chk(b_after == 1'b1, "R8 busy after start", b_after, 1);
            chk(wr_cnt == w * h, "R7 one write per pixel", wr_cnt, w * h);
            chk(ord_bad == 0, "R6 R7 row-major order and lane", ord_bad, 0);
            chk(gap == 1, "R8 done one cycle after last write", gap, 1);
        end else begin
            chk(wr_cnt == 0, "R9 no writes for empty command", wr_cnt, 0);
            chk(waited == 0, "R9 done right after start", waited, 0);
        end
        chk(dn2 == 1'b0, "R8 done lasts one cycle", dn2, 0);
        bad = 0; first = -1;
        for (int a = 0; a < 512; a++) begin
            if (fbm[a] !== expm[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (bad != 0)
            $display("FAIL %s word %0d: actual %h expected %h", tag, first, fbm[first], expm[first]);
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        for (int a = 0; a < 1024; a++) patm[a] = (a * 32'h9E37_79B1) ^ (a << 11) ^ 32'h5A17_C3E9;
        for (int a = 0; a < 512; a++) expm[a] = fb_init(a);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R8 reset busy", busy, 0);
        chk(done == 1'b0, "R8 reset done", done, 0);
        chk(fb_we == 1'b0, "R7 reset write strobe", fb_we, 0);
        chk(pat_re == 1'b0, "R7 reset tile read", pat_re, 0);

        run_cmd(0, 1, 0, 0,  3,  2, 13, 5,  0,  0,  8,  4, 8'h3C, 8'hC3, 0, "R1 R3 mask tile follows screen");
        run_cmd(1, 0, 0, 0, 10,  7, 17, 6,  0,  0,  5,  3, 0, 0, 0,         "R1 R4 full-depth tile follows screen");
        run_cmd(2, 0, 1, 0, 20,  9, 11, 7,  4,  1,  7,  6, 0, 0, 0,         "R2 R4 anchored full-depth tile");
        run_cmd(3, 1, 1, 0, 33, 14,  9, 5, 30, 27,  9, 10, 8'h11, 8'hEE, 0, "R2 R3 anchored mask beyond tile size");
        run_cmd(1, 0, 0, 1,  8,  2, 15, 4,  0,  0,  6,  5, 0, 0, 0,         "R5 XOR full-depth tile");
        run_cmd(0, 1, 1, 1,  9,  3, 15, 4,  2,  3,  5,  7, 8'hF0, 8'h0F, 0, "R5 XOR mask tile");
        run_cmd(2, 0, 0, 0,  0, 20, 64, 2,  0,  0, 32, 32, 0, 0, 0,         "R6 full-width rows");
        run_cmd(3, 1, 0, 1, 63, 31,  1, 1,  0,  0,  3,  3, 8'hAA, 8'h55, 0, "R6 last pixel of screen");
        run_cmd(0, 0, 0, 0,  5,  5,  0, 4,  0,  0,  4,  4, 0, 0, 0,         "R9 zero width");
        run_cmd(0, 0, 0, 0,  5,  5,  4, 0,  0,  0,  4,  4, 0, 0, 0,         "R9 zero height");
        run_cmd(0, 1, 0, 0,  5,  5,  4, 4,  0,  0,  0,  4, 1, 2, 0,         "R9 zero tile width");
        run_cmd(1, 0, 0, 0, 12, 10, 20, 6,  0,  0, 11,  9, 0, 0, 1,         "R10 start ignored while busy");

        for (int k = 0; k < 32; k++) begin
            int w, h;
            w = 1 + (k * 11) % 24;
            h = 1 + (k * 3) % 8;
            run_cmd(k % 4, k % 2, (k / 2) % 2, (k / 4) % 2,
                    (k * 13) % (65 - w), (k * 7) % (33 - h), w, h,
                    (k * 9) % 32, (k * 17) % 32, 1 + (k * 7) % 32, 1 + (k * 5) % 32,
                    (k * 37) % 256, (k * 91 + 5) % 256, 0, "R1 R2 R3 R4 R5 sweep");
        end

        summary();
        $finish;
    end
endmodule